// File: doc/BRIEF.md
# Double-Edge Column Data Serializer

This block sits between a pixel pipeline and the column drivers of a flat panel. Each pixel period it accepts one RGB pixel of `COLOR_W` bits per colour, together with a data-enable, and spreads every colour over `COLOR_W/2` narrow data lanes. Each lane carries two bits per pixel period, one while the forwarded lane clock is high and one while it is low. Receivers that latch on both clock edges therefore see the whole pixel. The lane bit rate is twice the pixel rate, for example 170 Mb/s per lane at an 85 MHz pixel rate. The pixel rate may lie anywhere from 40 to 85 MHz.

The block runs on a single clock `clk2x` at twice the pixel rate. A pixel strobe `px_ce` marks every second edge of that clock, and those are the edges that capture a pixel. Pixel data passes through a delay line of `LEAD` pixel stages. A horizontal start pulse is raised when data-enable is first captured high, so the pulse leads the first active pixel of every line on the lanes by exactly `LEAD` pixel periods. Captured idle slots put zeros on all lanes.

Top module: `colbus_serializer`

## Requirements
- R1: While `rst_n` is low at a `clk2x` edge, all lane outputs, `lane_clk` and `hstart` are 0 after that edge.
- R2: `px_ce` is high on every second `clk2x` edge. `lane_clk` is 1 for the fast cycle that follows a strobed edge and 0 for the fast cycle after that.
- R3: In the first half of a pixel period (`lane_clk` = 1), lane k of each colour carries colour bit 2k+1. With `COLOR_W` = 6, lanes 2, 1 and 0 carry bits 5, 3 and 1. Bit `COLOR_W-1` is the MSB.
- R4: In the second half (`lane_clk` = 0), lane k of each colour carries colour bit 2k. With `COLOR_W` = 6, lanes 2, 1 and 0 carry bits 4, 2 and 0.
- R5: `hstart` rises on the strobed edge that captures `de_in` = 1 when the previous captured `de_in` was 0. It stays high for exactly two fast cycles, which is one pixel period.
- R6: Every pixel reaches the lanes `LEAD` pixel periods (2*`LEAD` fast cycles) after the edge that captured it. The first active pixel of a line therefore starts exactly 2*`LEAD` fast cycles after `hstart` rises. `LEAD` is at least 2 and defaults to 2.
- R7: A pixel slot captured with `de_in` = 0 drives 0 on every lane in both halves, and no start pulse is raised for it.
- R8: Values on `de_in` and the colour inputs at edges where `px_ce` is 0 have no effect on any output.
- R9: While `de_in` is captured high on consecutive pixels, `hstart` is not raised again until `de_in` has been captured low and then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| px_ce | input | 1 | Pixel strobe, high on every second clk2x edge |
| de_in | input | 1 | Data-enable of the pixel presented with the strobe |
| red_in | input | COLOR_W | Red component |
| grn_in | input | COLOR_W | Green component |
| blu_in | input | COLOR_W | Blue component |
| lane_red | output | COLOR_W/2 | Red data lanes |
| lane_grn | output | COLOR_W/2 | Green data lanes |
| lane_blu | output | COLOR_W/2 | Blue data lanes |
| lane_clk | output | 1 | Forwarded lane clock, high in the first half of each pixel period |
| hstart | output | 1 | Horizontal start pulse, one pixel period wide |

## Verification
The start pulse is due on the edge that captures the pixel, so it is sampled on the falling edges 1 and 2 cycles after the driving edge. A pixel's first-half lane bits are due 2*`LEAD`+1 falling edges after it is driven and its second-half bits one edge later. The driver stamps each expected item with its due cycle from a free-running edge counter, and the monitor compares only when the head item's stamp equals the current cycle. An item that comes due late counts as a failure. Between strobes the driver inverts every input, so any leak through a non-strobed edge would corrupt a later comparison.

// File: rtl/cser_pkg.sv
`timescale 1ns/1ps
package cser_pkg;
    localparam int unsigned NUM_COLOURS = 3;

    // Level of the forwarded lane clock in each half of a pixel period
    typedef enum logic {
        PH_SECOND = 1'b0,
        PH_FIRST  = 1'b1
    } half_e;
endpackage

// File: rtl/px_delay.sv
`timescale 1ns/1ps
module px_delay #(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              de_i,
    input  logic [WORD_W-1:0] pix_i,
    output logic              tail_de_o,
    output logic [WORD_W-1:0] tail_pix_o
);
    typedef struct packed {
        logic [STAGES-1:0][WORD_W:0] stg;
    } dly_t;

    dly_t dly_d, dly_q;

    always_comb begin
        dly_d = dly_q;
        if (ce) begin
            dly_d.stg[0] = {de_i, (de_i ? pix_i : '0)};
            for (int i = 1; i < STAGES; i++) begin
                dly_d.stg[i] = dly_q.stg[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

    assign tail_de_o  = dly_q.stg[STAGES-1][WORD_W];
    assign tail_pix_o = dly_q.stg[STAGES-1][WORD_W-1:0];
endmodule

// File: rtl/hs_gen.sv
`timescale 1ns/1ps
module hs_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic de_i,
    output logic hs_o
);
    typedef struct packed {
        logic de_prev;
        logic hs;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (ce) begin
            hs_d.de_prev = de_i;
            hs_d.hs      = de_i & ~hs_q.de_prev;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign hs_o = hs_q.hs;

    AST_HS_ONE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q.hs && $past(hs_q.hs)) |=> !hs_q.hs); // R5
endmodule

// File: rtl/lane_ser.sv
`timescale 1ns/1ps
module lane_ser
    import cser_pkg::*;
#(
    parameter int unsigned COLOR_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ce,
    input  logic [NUM_COLOURS*COLOR_W-1:0]  word_i,
    output logic [NUM_COLOURS*(COLOR_W/2)-1:0] lanes_o,
    output logic                            lck_o
);
    localparam int unsigned LANES  = COLOR_W / 2;
    localparam int unsigned LANE_N = NUM_COLOURS * LANES;

    typedef struct packed {
        logic [LANE_N-1:0] hold;
        logic [LANE_N-1:0] lanes;
        half_e             ph;
    } ser_t;

    ser_t ser_d, ser_q;
    logic [LANE_N-1:0] odd_w, even_w;

    for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_col
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign odd_w[c*LANES+k]  = word_i[c*COLOR_W + 2*k + 1];
            assign even_w[c*LANES+k] = word_i[c*COLOR_W + 2*k];
        end
    end

    always_comb begin
        ser_d = ser_q;
        if (ce) begin
            ser_d.hold  = even_w;
            ser_d.lanes = odd_w;
            ser_d.ph    = PH_FIRST;
        end else begin
            ser_d.lanes = ser_q.hold;
            ser_d.ph    = PH_SECOND;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ser_q <= '{hold: '0, lanes: '0, ph: PH_SECOND};
        else        ser_q <= ser_d;
    end

    assign lanes_o = ser_q.lanes;
    assign lck_o   = (ser_q.ph == PH_FIRST);

    AST_LCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lck_o |=> !lck_o); // R2
endmodule

// File: rtl/colbus_serializer.sv
`timescale 1ns/1ps
module colbus_serializer
    import cser_pkg::*;
#(
    parameter int unsigned COLOR_W = 6,
    parameter int unsigned LEAD    = 2
) (
    input  logic                   clk2x,
    input  logic                   rst_n,
    input  logic                   px_ce,
    input  logic                   de_in,
    input  logic [COLOR_W-1:0]     red_in,
    input  logic [COLOR_W-1:0]     grn_in,
    input  logic [COLOR_W-1:0]     blu_in,
    output logic [COLOR_W/2-1:0]   lane_red,
    output logic [COLOR_W/2-1:0]   lane_grn,
    output logic [COLOR_W/2-1:0]   lane_blu,
    output logic                   lane_clk,
    output logic                   hstart
);
    localparam int unsigned LANES  = COLOR_W / 2;
    localparam int unsigned WORD_W = NUM_COLOURS * COLOR_W;
    localparam int unsigned LANE_N = NUM_COLOURS * LANES;

    logic              tail_de;
    logic [WORD_W-1:0] tail_pix;
    logic [LANE_N-1:0] lanes;

    px_delay #(.WORD_W(WORD_W), .STAGES(LEAD)) u_delay (
        .clk        (clk2x),
        .rst_n      (rst_n),
        .ce         (px_ce),
        .de_i       (de_in),
        .pix_i      ({red_in, grn_in, blu_in}),
        .tail_de_o  (tail_de),
        .tail_pix_o (tail_pix)
    );

    hs_gen u_hs (
        .clk   (clk2x),
        .rst_n (rst_n),
        .ce    (px_ce),
        .de_i  (de_in),
        .hs_o  (hstart)
    );

    lane_ser #(.COLOR_W(COLOR_W)) u_ser (
        .clk     (clk2x),
        .rst_n   (rst_n),
        .ce      (px_ce),
        .word_i  (tail_pix),
        .lanes_o (lanes),
        .lck_o   (lane_clk)
    );

    assign lane_red = lanes[3*LANES-1:2*LANES];
    assign lane_grn = lanes[2*LANES-1:LANES];
    assign lane_blu = lanes[LANES-1:0];

    AST_CE_ALTERNATES: assert property (@(posedge clk2x) disable iff (!rst_n)
        px_ce |=> !px_ce); // R2

    AST_HS_NEEDS_DE: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(hstart) |-> $past(px_ce && de_in)); // R7

    AST_HS_HOLDS: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(hstart) |=> hstart); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk2x) disable iff (!rst_n)
        (px_ce && !tail_de) |=> (lanes == '0)); // R7
endmodule

// File: tb/tb_colbus_serializer.sv
`timescale 1ns/1ps
module tb_colbus_serializer;
    localparam int CW   = 6;
    localparam int L    = CW / 2;
    localparam int LEAD = 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          px_ce = 1'b0;
    logic          de_in = 1'b0;
    logic [CW-1:0] red_in = '0, grn_in = '0, blu_in = '0;
    logic [L-1:0]  lane_red, lane_grn, lane_blu;
    logic          lane_clk, hstart;

    colbus_serializer #(.COLOR_W(CW), .LEAD(LEAD)) dut (
        .clk2x(clk), .rst_n(rst_n), .px_ce(px_ce), .de_in(de_in),
        .red_in(red_in), .grn_in(grn_in), .blu_in(blu_in),
        .lane_red(lane_red), .lane_grn(lane_grn), .lane_blu(lane_blu),
        .lane_clk(lane_clk), .hstart(hstart)
    );

    typedef struct packed {
        int           due;
        logic [L-1:0] r, g, b;
        logic         lck;
        logic [3:0]   req;
    } lane_item_t;

    typedef struct packed {
        int         due;
        logic       hs;
        logic [3:0] req;
    } hs_item_t;

    lane_item_t q_ln[$];
    hs_item_t   q_hs[$];
    lane_item_t li;
    hs_item_t   hi;

    int cyc = 0, checks = 0, errors = 0;
    bit prev_de = 1'b0;
    bit r8_mode = 1'b0;
    bit done    = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Lane k of a colour: bit 2k+1 in the first half (R3), bit 2k in the second (R4)
    function automatic logic [L-1:0] pick(input logic [CW-1:0] c, input bit second);
        for (int k = 0; k < L; k++) pick[k] = c[2*k + (second ? 0 : 1)];
    endfunction

    // Monitor: compares each expected item in the cycle it falls due
    always @(negedge clk) begin
        if (q_ln.size() != 0 && q_ln[0].due <= cyc) begin
            li = q_ln.pop_front();
            if (li.due != cyc) chk(1'b0, 6, cyc, li.due);  // R6 item came due late
            else begin
                chk({lane_red, lane_grn, lane_blu} == {li.r, li.g, li.b}, int'(li.req),
                    {lane_red, lane_grn, lane_blu}, {li.r, li.g, li.b});
                chk(lane_clk == li.lck, 2, lane_clk, li.lck);  // R2
            end
        end
        if (q_hs.size() != 0 && q_hs[0].due <= cyc) begin
            hi = q_hs.pop_front();
            if (hi.due != cyc) chk(1'b0, 5, cyc, hi.due);
            else chk(hstart == hi.hs, int'(hi.req), hstart, hi.hs);  // R5 / R7 / R9
        end
    end

    // Driver: one pixel per call, inputs inverted on the non-strobed edge (R8)
    task automatic send(input bit de, input logic [CW-1:0] r, g, b, input bit push);
        bit rise;
        logic [CW-1:0] mr, mg, mb;
        int hreq, req1;
        @(negedge clk);
        px_ce = 1'b1; de_in = de; red_in = r; grn_in = g; blu_in = b;
        rise = de && !prev_de;
        prev_de = de;
        mr = de ? r : '0; mg = de ? g : '0; mb = de ? b : '0;
        if (push) begin
            hreq = rise ? 5 : (de ? 9 : 7);                    // R5, R9, R7
            req1 = !de ? 7 : (rise ? 6 : (r8_mode ? 8 : 3));   // R7, R6, R8, R3
            q_hs.push_back('{due: cyc + 1, hs: rise, req: 4'(hreq)});
            q_hs.push_back('{due: cyc + 2, hs: rise, req: 4'(hreq)});
            q_ln.push_back('{due: cyc + 1 + 2*LEAD, r: pick(mr, 1'b0), g: pick(mg, 1'b0),
                             b: pick(mb, 1'b0), lck: 1'b1, req: 4'(req1)});
            q_ln.push_back('{due: cyc + 2 + 2*LEAD, r: pick(mr, 1'b1), g: pick(mg, 1'b1),
                             b: pick(mb, 1'b1), lck: 1'b0, req: (de ? 4'd4 : 4'd7)});  // R4
        end
        @(negedge clk);
        px_ce = 1'b0; de_in = !de; red_in = ~r; grn_in = ~g; blu_in = ~b;
    endtask

    initial begin
        // R1: reset state
        repeat (2) begin
            @(negedge clk); px_ce = 1'b1; de_in = 1'b1; red_in = '1;
            @(negedge clk); px_ce = 1'b0;
        end
        chk({lane_red, lane_grn, lane_blu} == '0, 1, {lane_red, lane_grn, lane_blu}, 0);
        chk(lane_clk == 1'b0, 1, lane_clk, 0);
        chk(hstart == 1'b0, 1, hstart, 0);
        de_in = 1'b0; red_in = '0;
        @(negedge clk); rst_n = 1'b1;

        repeat (3) send(1'b0, 6'h3F, 6'h3F, 6'h3F, 1'b1);            // R7 idle
        // Line 1: walking ones, complements, counts (R3, R4, R6)
        for (int i = 0; i < 8; i++)
            send(1'b1, 6'(1 << (i % CW)), ~6'(1 << (i % CW)), 6'(i * 9), 1'b1);
        send(1'b1, 6'h3F, 6'h00, 6'h2A, 1'b1);
        send(1'b1, 6'h15, 6'h2A, 6'h3F, 1'b1);
        repeat (3) send(1'b0, 6'h2A, 6'h15, 6'h33, 1'b1);
        // Line 2: single-pixel line
        send(1'b1, 6'h21, 6'h12, 6'h0C, 1'b1);
        repeat (2) send(1'b0, 6'h3F, 6'h3F, 6'h3F, 1'b1);
        // Line 3: long line, no second start pulse (R9), inputs scrambled between strobes (R8)
        r8_mode = 1'b1;
        for (int i = 0; i < 12; i++)
            send(1'b1, 6'(i * 5 + 1), 6'(63 - i * 3), 6'(i * 7), 1'b1);
        r8_mode = 1'b0;
        repeat (LEAD + 3) send(1'b0, 6'h00, 6'h00, 6'h00, 1'b1);
        repeat (LEAD + 3) send(1'b0, 6'h00, 6'h00, 6'h00, 1'b0);
        chk(q_ln.size() == 0, 6, q_ln.size(), 0);
        chk(q_hs.size() == 0, 5, q_hs.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule